// File: doc/BRIEF.md
# Sector-Aware Flash Write Sequencer

This block turns one write request of any length into the sequence of sector reads, sector erases and range programs that a flash with 4096-byte erase sectors needs. The request is given as a start address and a byte count. The new data is fetched from a caller-owned source through a byte-index port. The flash itself is reached through three abstract command ports: one reads a whole sector, one erases a sector, and one programs an address range. Each command port uses a one-cycle request strobe and a done strobe. The sequencer sits between a host that wants byte-granular writes and a flash controller that only understands those three commands.

The request is cut at every sector boundary. For each piece (a chunk), the whole sector is streamed into a local 4096-byte buffer. While the bytes stream in, only the bytes the chunk will overwrite are tested for the erased value 0xFF. If all of them are erased, the chunk is programmed straight from the source at its own address. If any of them is not erased, the sector is erased. The new bytes are then merged into the buffer at the chunk offset, and the full buffer is programmed back from the sector base. Bytes that lie outside the target range are kept.

The controller is a single FSM with these states:
- `S_IDLE`: waits for `start`.
- `S_RD_REQ` and `S_RD_WAIT`: issue the sector read and wait for it, filling the buffer and the blank check.
- `S_DECIDE`: picks the path for the chunk.
- `S_ER_REQ` and `S_ER_WAIT`: issue the erase and wait for it.
- `S_MERGE`: copies the new bytes into the buffer.
- `S_PG_REQ` and `S_PG_RUN`: issue the program and stream its data.
- `S_NEXT`: moves to the following chunk.
- `S_DONE`: gives the completion pulse.

The transitions are:
- `S_IDLE`→`S_RD_REQ` when `start` arrives with a non-zero count.
- `S_IDLE`→`S_DONE` when `start` arrives with a zero count.
- `S_RD_REQ`→`S_RD_WAIT` always.
- `S_RD_WAIT`→`S_DECIDE` on read done.
- `S_DECIDE`→`S_PG_REQ` when the target is blank.
- `S_DECIDE`→`S_ER_REQ` when the target is dirty.
- `S_ER_REQ`→`S_ER_WAIT` always.
- `S_ER_WAIT`→`S_MERGE` on erase done.
- `S_MERGE`→`S_PG_REQ` after the last chunk byte.
- `S_PG_REQ`→`S_PG_RUN` always.
- `S_PG_RUN`→`S_NEXT` on program done.
- `S_NEXT`→`S_DONE` when this chunk was the last one.
- `S_NEXT`→`S_RD_REQ` otherwise.
- `S_DONE`→`S_IDLE` always.

Top module: `sector_write_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `rd_req`, `er_req` and `pg_req` are all low.
- R2: A request at address A with count N is split into chunks. The first chunk is min(N, 4096 − (A mod 4096)) bytes. Each later chunk starts at offset 0 of the next sector (sector index = address / 4096, plus one) and is min(remaining, 4096) bytes. No program command crosses a sector boundary.
- R3: Each chunk starts with one read request whose `rd_addr` is the sector base (low 12 bits zero). The read then expects exactly 4096 bytes on `rd_vld`/`rd_byte`, in address order, followed by `rd_done`.
- R4: The blank check looks only at the chunk's target bytes. If every one of them reads 0xFF, no erase is issued, even when other bytes of the sector hold data. One program is then issued with `pg_addr` equal to the chunk address and `pg_len` equal to the chunk length, carrying the source bytes.
- R5: If any target byte is not 0xFF, an erase is issued at the sector base. It is followed by one program with `pg_addr` at the sector base and `pg_len` = 4096. The data programmed is the sector as read, with the target bytes replaced by the new data.
- R6: Each request strobe lasts one cycle, at most one strobe is high in any cycle, and no further command is issued until the current one's done strobe arrives.
- R7: `done` pulses for exactly one cycle, once per accepted request, after the final program's done strobe. `busy` is low again from the cycle that follows.
- R8: A request with a count of zero produces the `done` pulse and issues no read, erase or program.
- R9: A `start` pulse while `busy` is high is ignored. It causes no extra command and no extra `done`, and it does not change the data written.
- R10: `src_idx` gives the position within the request of the byte wanted on `src_byte`, where index 0 is the byte for the start address. During a program, a byte is consumed on each `pg_next`, and `pg_byte` then moves on to the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a write request when idle |
| wr_addr | input | ADDR_W | Flash byte address of the first byte |
| wr_len | input | LEN_W | Number of bytes to write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_idx | output | LEN_W | Index of the wanted source byte |
| src_byte | input | 8 | Source byte at `src_idx`, same cycle |
| rd_req | output | 1 | Sector read request strobe |
| rd_addr | output | ADDR_W | Sector base to read |
| rd_vld | input | 1 | A read byte is present |
| rd_byte | input | 8 | Read data byte |
| rd_done | input | 1 | Sector read finished |
| er_req | output | 1 | Sector erase request strobe |
| er_addr | output | ADDR_W | Sector base to erase |
| er_done | input | 1 | Erase finished |
| pg_req | output | 1 | Program request strobe |
| pg_addr | output | ADDR_W | First address to program |
| pg_len | output | SECT_W+1 | Number of bytes to program |
| pg_byte | output | 8 | Current program data byte |
| pg_next | input | 1 | Current program byte consumed |
| pg_done | input | 1 | Program finished |

## Verification
The flash model applies programs as a bitwise AND onto the stored bytes. Because of this, a missed erase or wrongly merged data shows up as corrupted contents, not as a silently correct result.

The tests cover these patterns:
- A write into an erased area, and an overwrite of the same bytes. Together these separate the direct path from the erase-merge-rewrite path.
- A write whose target is blank inside a sector that holds data elsewhere. This shows that only the target bytes are tested.
- A write straddling a boundary, and an 8192-byte write that is neither aligned nor sector-sized. These show the chunk lengths: short first, full middle, short last.
- A sector-aligned full-sector write, a zero-count request, and a `start` issued mid-operation. These cover the edge cases of chunking, completion and request acceptance.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_DECIDE,
        S_ER_REQ,
        S_ER_WAIT,
        S_MERGE,
        S_PG_REQ,
        S_PG_RUN,
        S_NEXT,
        S_DONE
    } sws_state_e;

    typedef logic [7:0] byte_t;

    localparam byte_t ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/sws_sector_buf.sv
module sws_sector_buf #(
    parameter int SECT_W = 12
) (
    input  logic                clk,
    input  logic                we,
    input  logic [SECT_W-1:0]   waddr,
    input  sws_pkg::byte_t      wdata,
    input  logic [SECT_W-1:0]   raddr,
    output sws_pkg::byte_t      rdata
);
    localparam int DEPTH = 1 << SECT_W;

    sws_pkg::byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sws_chunk_calc.sv
module sws_chunk_calc #(
    parameter int SECT_W = 12,
    parameter int LEN_W  = 16
) (
    input  logic [SECT_W-1:0] offset,
    input  logic [LEN_W-1:0]  remaining,
    output logic [SECT_W:0]   chunk
);
    localparam logic [SECT_W:0] SECT_BYTES = (SECT_W+1)'(1) << SECT_W;

    logic [SECT_W:0] room;
    logic            fits;

    always_comb begin
        room  = SECT_BYTES - {1'b0, offset};
        fits  = remaining < LEN_W'(room);
        chunk = fits ? remaining[SECT_W:0] : room;
    end

endmodule

// File: rtl/sws_blank_scan.sv
module sws_blank_scan #(
    parameter int SECT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                vld,
    input  logic [SECT_W:0]     idx,
    input  sws_pkg::byte_t      byte_in,
    input  logic [SECT_W-1:0]   lo,
    input  logic [SECT_W:0]     len,
    output logic                dirty
);
    logic [SECT_W+1:0] lo_x;
    logic [SECT_W+1:0] hi_x;
    logic [SECT_W+1:0] idx_x;
    logic              in_range;

    always_comb begin
        lo_x     = {2'b00, lo};
        hi_x     = lo_x + {1'b0, len};
        idx_x    = {1'b0, idx};
        in_range = (idx_x >= lo_x) && (idx_x < hi_x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (clear) begin
            dirty <= 1'b0;
        end else if (vld && in_range && (byte_in != sws_pkg::ERASED_BYTE)) begin
            dirty <= 1'b1;
        end
    end

endmodule

// File: rtl/sector_write_sequencer.sv
module sector_write_sequencer #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int SECT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [LEN_W-1:0]    wr_len,
    output logic                busy,
    output logic                done,
    output logic [LEN_W-1:0]    src_idx,
    input  logic [7:0]          src_byte,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_vld,
    input  logic [7:0]          rd_byte,
    input  logic                rd_done,
    output logic                er_req,
    output logic [ADDR_W-1:0]   er_addr,
    input  logic                er_done,
    output logic                pg_req,
    output logic [ADDR_W-1:0]   pg_addr,
    output logic [SECT_W:0]     pg_len,
    output logic [7:0]          pg_byte,
    input  logic                pg_next,
    input  logic                pg_done
);
    import sws_pkg::*;

    localparam int              IDX_W      = ADDR_W - SECT_W;
    localparam logic [SECT_W:0] SECT_BYTES = (SECT_W+1)'(1) << SECT_W;

    sws_state_e state_q, state_d;

    logic [IDX_W-1:0]  sec_idx_q;
    logic [SECT_W-1:0] off_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  consumed_q;
    logic [SECT_W:0]   chunk_q;
    logic [SECT_W:0]   cnt_q;
    logic [SECT_W:0]   chunk_c;
    logic              dirty;
    logic              last_chunk;

    logic              buf_we;
    logic [SECT_W-1:0] buf_waddr;
    byte_t             buf_wdata;
    byte_t             buf_rdata;
    logic [ADDR_W-1:0] sec_base;

    sws_chunk_calc #(.SECT_W(SECT_W), .LEN_W(LEN_W)) u_chunk (
        .offset    (off_q),
        .remaining (remain_q),
        .chunk     (chunk_c)
    );

    sws_blank_scan #(.SECT_W(SECT_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == S_RD_REQ),
        .vld     ((state_q == S_RD_WAIT) && rd_vld),
        .idx     (cnt_q),
        .byte_in (rd_byte),
        .lo      (off_q),
        .len     (chunk_q),
        .dirty   (dirty)
    );

    sws_sector_buf #(.SECT_W(SECT_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (cnt_q[SECT_W-1:0]),
        .rdata (buf_rdata)
    );

    assign sec_base   = {sec_idx_q, {SECT_W{1'b0}}};
    assign last_chunk = (remain_q == LEN_W'(chunk_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (wr_len == '0) ? S_DONE : S_RD_REQ;
                end
            end
            S_RD_REQ:  state_d = S_RD_WAIT;
            S_RD_WAIT: if (rd_done) state_d = S_DECIDE;
            S_DECIDE:  state_d = dirty ? S_ER_REQ : S_PG_REQ;
            S_ER_REQ:  state_d = S_ER_WAIT;
            S_ER_WAIT: if (er_done) state_d = S_MERGE;
            S_MERGE:   if (cnt_q == chunk_q - 1'b1) state_d = S_PG_REQ;
            S_PG_REQ:  state_d = S_PG_RUN;
            S_PG_RUN:  if (pg_done) state_d = S_NEXT;
            S_NEXT:    state_d = last_chunk ? S_DONE : S_RD_REQ;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_idx_q  <= '0;
            off_q      <= '0;
            remain_q   <= '0;
            consumed_q <= '0;
            chunk_q    <= '0;
            cnt_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        sec_idx_q  <= wr_addr[ADDR_W-1:SECT_W];
                        off_q      <= wr_addr[SECT_W-1:0];
                        remain_q   <= wr_len;
                        consumed_q <= '0;
                    end
                end
                S_RD_REQ: begin
                    cnt_q   <= '0;
                    chunk_q <= chunk_c;
                end
                S_RD_WAIT: if (rd_vld) cnt_q <= cnt_q + 1'b1;
                S_ER_WAIT: if (er_done) cnt_q <= '0;
                S_MERGE:   cnt_q <= cnt_q + 1'b1;
                S_PG_REQ:  cnt_q <= '0;
                S_PG_RUN:  if (pg_next) cnt_q <= cnt_q + 1'b1;
                S_NEXT: begin
                    remain_q   <= remain_q - LEN_W'(chunk_q);
                    consumed_q <= consumed_q + LEN_W'(chunk_q);
                    sec_idx_q  <= sec_idx_q + 1'b1;
                    off_q      <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
        rd_req    = (state_q == S_RD_REQ);
        er_req    = (state_q == S_ER_REQ);
        pg_req    = (state_q == S_PG_REQ);
        rd_addr   = sec_base;
        er_addr   = sec_base;
        pg_addr   = dirty ? sec_base : {sec_idx_q, off_q};
        pg_len    = dirty ? SECT_BYTES : chunk_q;
        src_idx   = consumed_q;
        pg_byte   = buf_rdata;
        buf_we    = 1'b0;
        buf_waddr = cnt_q[SECT_W-1:0];
        buf_wdata = rd_byte;
        unique case (state_q)
            S_RD_WAIT: begin
                buf_we = rd_vld;
            end
            S_MERGE: begin
                src_idx   = consumed_q + LEN_W'(cnt_q);
                buf_we    = 1'b1;
                buf_waddr = off_q + cnt_q[SECT_W-1:0];
                buf_wdata = src_byte;
            end
            S_PG_RUN: begin
                src_idx = consumed_q + LEN_W'(cnt_q);
                pg_byte = dirty ? buf_rdata : src_byte;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sector_write_sequencer_chk.sv
module sector_write_sequencer_chk #(
    parameter int ADDR_W = 24,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              er_req,
    input  logic [ADDR_W-1:0] er_addr,
    input  logic              pg_req,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [SECT_W:0]   pg_len
);
    localparam logic [SECT_W+1:0] SECT_X = (SECT_W+2)'(1) << SECT_W;

    // R6
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_req, er_req, pg_req}) <= 1);

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || er_req || pg_req) |=> !(rd_req || er_req || pg_req));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    pg_in_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> (pg_len != '0) &&
                   (({2'b00, pg_addr[SECT_W-1:0]} + {1'b0, pg_len}) <= SECT_X));

    // R5
    full_at_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req && ({1'b0, pg_len} == SECT_X)) |-> (pg_addr[SECT_W-1:0] == '0));

    // R3
    rd_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[SECT_W-1:0] == '0));

    // R5
    er_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        er_req |-> (er_addr[SECT_W-1:0] == '0));

endmodule

bind sector_write_sequencer sector_write_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .er_req  (er_req),
    .er_addr (er_addr),
    .pg_req  (pg_req),
    .pg_addr (pg_addr),
    .pg_len  (pg_len)
);

// File: tb/sector_write_sequencer_tb_top.sv
module sector_write_sequencer_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ADDR_W = 24;
    localparam int LEN_W  = 16;
    localparam int SECT_W = 12;
    localparam int SECT   = 1 << SECT_W;
    localparam int MEMSZ  = 4 * SECT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [LEN_W-1:0]  wr_len = '0;
    logic              busy, done;
    logic [LEN_W-1:0]  src_idx;
    logic [7:0]        src_byte;
    logic              rd_req, er_req, pg_req;
    logic [ADDR_W-1:0] rd_addr, er_addr, pg_addr;
    logic [SECT_W:0]   pg_len;
    logic [7:0]        pg_byte;
    logic              rd_vld = 1'b0, rd_done = 1'b0, er_done = 1'b0;
    logic              pg_next = 1'b0, pg_done = 1'b0;
    logic [7:0]        rd_byte = '0;

    logic [7:0] flash_m [MEMSZ];
    logic [7:0] exp_m   [MEMSZ];
    logic [7:0] src_m   [8192];

    int n_rd, n_er, n_pg, n_done;
    int pg_a [16];
    int pg_l [16];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign src_byte = src_m[src_idx[12:0]];

    sector_write_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECT_W(SECT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_addr(wr_addr), .wr_len(wr_len),
        .busy(busy), .done(done), .src_idx(src_idx), .src_byte(src_byte),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_byte(rd_byte),
        .rd_done(rd_done), .er_req(er_req), .er_addr(er_addr), .er_done(er_done),
        .pg_req(pg_req), .pg_addr(pg_addr), .pg_len(pg_len), .pg_byte(pg_byte),
        .pg_next(pg_next), .pg_done(pg_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // flash model: read streams, erase fills 0xFF, program ANDs bytes in
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                int a;
                a = int'(rd_addr) % MEMSZ;
                n_rd++;
                @(negedge clk);
                for (int i = 0; i < SECT; i++) begin
                    rd_vld  = 1'b1;
                    rd_byte = flash_m[(a + i) % MEMSZ];
                    @(negedge clk);
                end
                rd_vld  = 1'b0;
                rd_done = 1'b1;
                @(negedge clk);
                rd_done = 1'b0;
            end else if (er_req) begin
                int a;
                a = int'(er_addr) % MEMSZ;
                n_er++;
                @(negedge clk);
                for (int i = 0; i < SECT; i++) flash_m[(a + i) % MEMSZ] = 8'hFF;
                repeat (3) @(negedge clk);
                er_done = 1'b1;
                @(negedge clk);
                er_done = 1'b0;
            end else if (pg_req) begin
                int a;
                int l;
                a = int'(pg_addr) % MEMSZ;
                l = int'(pg_len);
                if (n_pg < 16) begin
                    pg_a[n_pg] = int'(pg_addr);
                    pg_l[n_pg] = l;
                end
                n_pg++;
                @(negedge clk);
                for (int i = 0; i < l; i++) begin
                    pg_next = 1'b1;
                    flash_m[(a + i) % MEMSZ] = flash_m[(a + i) % MEMSZ] & pg_byte;
                    @(negedge clk);
                end
                pg_next = 1'b0;
                pg_done = 1'b1;
                @(negedge clk);
                pg_done = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done) n_done++;
        end
    end

    task automatic fill_src(input int seed);
        for (int i = 0; i < 8192; i++) src_m[i] = 8'((i * 13 + seed) % 255);
    endtask

    task automatic run_op(input int addr, input int len, input bit poke_mid);
        int wait_c;
        n_rd = 0; n_er = 0; n_pg = 0; n_done = 0;
        @(negedge clk);
        start   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_len  = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) exp_m[addr + i] = src_m[i];
        if (poke_mid) begin
            repeat (50) @(negedge clk);
            start   = 1'b1;
            wr_addr = '0;
            wr_len  = 16'd4;
            @(negedge clk);
            start = 1'b0;
        end
        wait_c = 0;
        while (n_done == 0 && wait_c < 60000) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (20) @(negedge clk);
        check(n_done == 1, "R7 done count", n_done, 1);
        check(busy == 1'b0, "R7 busy after done", int'(busy), 0);
    endtask

    task automatic cmp_flash(input string tag);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int i = 0; i < MEMSZ; i++) begin
            if (flash_m[i] !== exp_m[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, tag, first, -1);
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check({rd_req, er_req, pg_req} == 3'b000, "R1 strobes", int'({rd_req, er_req, pg_req}), 0);
    endtask

    task automatic t_direct;
        fill_src(1);
        run_op(32'h0100, 16, 1'b0);
        check(n_er == 0, "R4 no erase", n_er, 0);
        check(n_pg == 1 && pg_a[0] == 32'h0100 && pg_l[0] == 16, "R4 program addr", pg_a[0], 32'h0100);
        cmp_flash("R10 direct contents");
    endtask

    task automatic t_dirty;
        fill_src(2);
        run_op(32'h0108, 16, 1'b0);
        check(n_er == 1, "R5 erase count", n_er, 1);
        check(n_pg == 1 && pg_a[0] == 0 && pg_l[0] == SECT, "R5 full program len", pg_l[0], SECT);
        check(n_rd == 1, "R3 read count", n_rd, 1);
        cmp_flash("R5 merged contents");
    endtask

    task automatic t_blank_target;
        fill_src(3);
        run_op(32'h3100, 8, 1'b0);
        check(n_er == 0, "R4 target-only blank check", n_er, 0);
        check(n_pg == 1 && pg_a[0] == 32'h3100 && pg_l[0] == 8, "R4 direct addr", pg_a[0], 32'h3100);
        cmp_flash("R4 contents");
    endtask

    task automatic t_boundary;
        fill_src(4);
        run_op(32'h0FF0, 48, 1'b0);
        check(n_rd == 2, "R2 read count", n_rd, 2);
        check(n_er == 1, "R5 boundary erase", n_er, 1);
        check(n_pg == 2 && pg_a[0] == 0 && pg_l[0] == SECT, "R2 first chunk rewrite", pg_l[0], SECT);
        check(pg_a[1] == 32'h1000 && pg_l[1] == 32, "R2 second chunk len", pg_l[1], 32);
        cmp_flash("R2 boundary contents");
    endtask

    task automatic t_long;
        fill_src(5);
        run_op(32'h1800, 8192, 1'b0);
        check(n_rd == 3, "R2 long read count", n_rd, 3);
        check(n_er == 1, "R5 long erase count", n_er, 1);
        check(n_pg == 3 && pg_a[0] == 32'h1800 && pg_l[0] == 2048, "R2 first short chunk", pg_l[0], 2048);
        check(pg_a[1] == 32'h2000 && pg_l[1] == SECT, "R2 middle full chunk", pg_l[1], SECT);
        check(pg_a[2] == 32'h3000 && pg_l[2] == SECT, "R5 last chunk rewrite", pg_l[2], SECT);
        cmp_flash("R10 long contents");
    endtask

    task automatic t_zero;
        run_op(32'h0200, 0, 1'b0);
        check(n_rd + n_er + n_pg == 0, "R8 no commands", n_rd + n_er + n_pg, 0);
        cmp_flash("R8 contents");
    endtask

    task automatic t_aligned_busy;
        fill_src(6);
        run_op(32'h2000, 4096, 1'b1);
        check(n_rd == 1, "R9 single read", n_rd, 1);
        check(n_er == 1 && n_pg == 1 && pg_a[0] == 32'h2000, "R9 aligned rewrite", pg_a[0], 32'h2000);
        cmp_flash("R9 contents");
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) flash_m[i] = 8'hFF;
        for (int i = 0; i < 64; i++) flash_m[i] = 8'(i + 3);
        flash_m[32'h0FF8] = 8'h5A;
        for (int i = 0; i < 16; i++) flash_m[32'h3000 + i] = 8'(i * 5);
        for (int i = 0; i < MEMSZ; i++) exp_m[i] = flash_m[i];
        n_rd = 0; n_er = 0; n_pg = 0; n_done = 0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_direct();
        t_dirty();
        t_blank_target();
        t_boundary();
        t_long();
        t_zero();
        t_aligned_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule